// File: doc/BRIEF.md
# PTP Target-Time Trigger

This block fires a single scheduled event when a free-running time-of-day reaches a programmed moment. The time comes in as a seconds count and a sub-second count, both in the PTP clock domain. Software programs a target seconds value and a target sub-second value over a simple register port on its own clock. Writing the sub-second register commits the pair. The pair then crosses into the PTP domain, and a busy flag stays high while the transfer runs.

Once the target has arrived, the trigger is armed. The block compares the running time against the target with an "at or past" test, so time that advances in coarse steps cannot jump over the target. The first PTP edge that sees the time at or past the target fires the event and disarms the trigger. The trigger mode held with the target chooses the action: raise an interrupt, raise an interrupt and start the PPS output, or stop the PPS output silently. The interrupt is recorded in a sticky status bit on the register clock. A mask bit gates it onto the interrupt pin.

The register port has no back-pressure. A write is taken in the cycle that `bus_wr_en` is high. Reads are combinational on `bus_rd_addr`. No valid/ready stream crosses the block's edge.

Top module: `ptp_tt_trig`

## Requirements
- R1: After reset, all four registers read 0, the busy flag is 0, `irq` is 0 and `pps_run` is 0.
- R2: A write to address 1 (target sub-second) that is accepted commits the pair. Busy (address 1, bit 31) reads 1 from the next register cycle. It returns to 0 without further action, within 20 register cycles.
- R3: While busy reads 1, writes to address 0 (target seconds) and address 1 are dropped, and both registers keep their values.
- R4: The event never fires while the running time is below the target. Below means a lower seconds value, or equal seconds with a lower sub-second value.
- R5: The event fires on the first PTP edge at which the running time is at or past the target, even when the time steps over the exact target. `pps_run` changes on that same edge.
- R6: The action depends on the mode in address 2, bits 1:0, captured at commit. Modes 0 and 1 set the interrupt only. Mode 2 sets the interrupt and drives `pps_run` to 1. Mode 3 drives `pps_run` to 0 and sets no interrupt.
- R7: The trigger is one-shot. After it fires, it does not fire again until a new committed pair arrives in the PTP domain.
- R8: The interrupt status (address 3, bit 0) is sticky. Writing 1 to that bit clears it. `irq` is the status bit gated by the enable in address 2, bit 4.
- R9: With decimal rollover selected (address 2, bit 8 = 1), a sub-second write above 999,999,999 is dropped and no transfer starts. With binary rollover (bit 8 = 0), any 31-bit value is accepted.
- R10: A target just after a seconds boundary fires correctly when the sub-second count wraps. In decimal mode the wrap is at 10^9. In binary mode it is at 2^31.
- R11: Address 1, bits 30:0, hold the written target sub-second value. Bit 31 is read-only and ignores the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-port clock |
| rst_reg_n | input | 1 | Active-low asynchronous reset, register domain |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_addr | input | 2 | Write address: 0 seconds, 1 sub-second, 2 control, 3 status |
| bus_wr_data | input | 32 | Write data |
| bus_rd_addr | input | 2 | Read address |
| bus_rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt, register domain |
| clk_ptp | input | 1 | PTP time clock |
| rst_ptp_n | input | 1 | Active-low asynchronous reset, PTP domain |
| now_sec | input | 32 | Running time, seconds |
| now_ns | input | 31 | Running time, sub-second count |
| pps_run | output | 1 | PPS output enable level, PTP domain |

## Verification
Register writes are visible on the read port one register cycle after the write edge. Busy rises in that same cycle. Busy then falls after two PTP synchroniser stages, one capture edge and two register synchroniser stages, so the bench polls it with a 20-cycle limit instead of expecting one exact cycle.

`pps_run` changes on the PTP edge that first sees the reached time. The scoreboard monitor samples on the following falling edge. It compares the time the design saw, which is the value held over the previous falling edge, against the queued target and the step size. The interrupt status reaches the register domain about three register cycles after the event. The bench reads it only after the bench time has passed the target and 12 more register cycles have elapsed.

// File: rtl/ptp_tt_pkg.sv
package ptp_tt_pkg;

  // Trigger action selected at commit time.
  typedef enum logic [1:0] {
    TRIG_IRQ       = 2'd0,
    TRIG_IRQ_ALT   = 2'd1,
    TRIG_IRQ_START = 2'd2,
    TRIG_STOP      = 2'd3
  } trig_mode_e;

  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] A_SEC  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_NS   = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [REG_ADDR_W-1:0] A_STAT = 2'd3;

  localparam int unsigned CTRL_IRQ_EN_BIT = 4;
  localparam int unsigned CTRL_DEC_BIT    = 8;

  // Largest sub-second value in decimal rollover mode.
  localparam int unsigned NS_DEC_LIMIT = 999_999_999;

endpackage

// File: rtl/ptp_tt_sync.sv
module ptp_tt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ptp_tt_regs.sv
module ptp_tt_regs
  import ptp_tt_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 31,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  ack_sync,
  input  logic                  evt_sync,
  output logic                  req_tgl,
  output logic                  busy,
  output logic                  status,
  output logic                  irq_en,
  output logic [SEC_W-1:0]      tgt_sec,
  output logic [NS_W-1:0]       tgt_ns,
  output trig_mode_e            tgt_mode,
  output logic                  irq
);

  trig_mode_e      mode_q;
  logic            dec_q;
  logic            evt_seen;
  logic [NS_W-1:0] ns_in;
  logic            ns_in_range;
  logic            wr_sec_ok;
  logic            wr_ns_ok;
  logic            wr_ctrl;
  logic            clr_stat;
  logic            evt_new;
  logic [DATA_W-1:0] ctrl_rd;

  // A transfer is outstanding while the returned acknowledge lags the request.
  assign busy        = req_tgl ^ ack_sync;
  assign ns_in       = wr_data[NS_W-1:0];
  assign ns_in_range = !dec_q || (ns_in <= NS_W'(NS_DEC_LIMIT));
  assign wr_sec_ok   = wr_en && (wr_addr == A_SEC) && !busy;
  assign wr_ns_ok    = wr_en && (wr_addr == A_NS) && !busy && ns_in_range;
  assign wr_ctrl     = wr_en && (wr_addr == A_CTRL);
  assign clr_stat    = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign evt_new     = evt_sync ^ evt_seen;

  // Target registers double as the source-side hold: frozen while busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_sec  <= '0;
      tgt_ns   <= '0;
      tgt_mode <= TRIG_IRQ;
      req_tgl  <= 1'b0;
    end else begin
      if (wr_sec_ok) tgt_sec <= wr_data[SEC_W-1:0];
      if (wr_ns_ok) begin
        tgt_ns   <= ns_in;
        tgt_mode <= mode_q;
        req_tgl  <= ~req_tgl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_IRQ;
      irq_en <= 1'b0;
      dec_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= trig_mode_e'(wr_data[1:0]);
      irq_en <= wr_data[CTRL_IRQ_EN_BIT];
      dec_q  <= wr_data[CTRL_DEC_BIT];
    end
  end

  // Sticky status; a new event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_seen <= 1'b0;
      status   <= 1'b0;
    end else begin
      evt_seen <= evt_sync;
      if (evt_new)       status <= 1'b1;
      else if (clr_stat) status <= 1'b0;
    end
  end

  assign irq = status & irq_en;

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[1:0]             = mode_q;
    ctrl_rd[CTRL_IRQ_EN_BIT] = irq_en;
    ctrl_rd[CTRL_DEC_BIT]    = dec_q;
  end

  always_comb begin
    unique case (rd_addr)
      A_SEC:   rd_data = DATA_W'(tgt_sec);
      A_NS:    rd_data = {busy, tgt_ns};
      A_CTRL:  rd_data = ctrl_rd;
      default: rd_data = DATA_W'(status);
    endcase
  end

endmodule

// File: rtl/ptp_tt_cmp.sv
module ptp_tt_cmp
  import ptp_tt_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned NS_W  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic [SEC_W-1:0] src_sec,
  input  logic [NS_W-1:0]  src_ns,
  input  trig_mode_e       src_mode,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  output logic             ack_tgl,
  output logic             evt_tgl,
  output logic             pps_run
);

  logic             req_seen;
  logic             load;
  logic [SEC_W-1:0] cap_sec;
  logic [NS_W-1:0]  cap_ns;
  trig_mode_e       cap_mode;
  logic             armed;
  logic             reached;
  logic             fire;

  assign load = req_sync ^ req_seen;

  // Ordered compare on (seconds, sub-second): the seconds carry of either
  // rollover style is absorbed because the sub-second field wraps into it.
  assign reached = (now_sec > cap_sec) ||
                   ((now_sec == cap_sec) && (now_ns >= cap_ns));
  assign fire    = armed && reached && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      cap_sec  <= '0;
      cap_ns   <= '0;
      cap_mode <= TRIG_IRQ;
      armed    <= 1'b0;
      ack_tgl  <= 1'b0;
      evt_tgl  <= 1'b0;
      pps_run  <= 1'b0;
    end else begin
      req_seen <= req_sync;
      if (load) begin
        cap_sec  <= src_sec;
        cap_ns   <= src_ns;
        cap_mode <= src_mode;
        armed    <= 1'b1;
        ack_tgl  <= ~ack_tgl;
      end else if (fire) begin
        armed <= 1'b0;
        unique case (cap_mode)
          TRIG_IRQ_START: begin
            pps_run <= 1'b1;
            evt_tgl <= ~evt_tgl;
          end
          TRIG_STOP: pps_run <= 1'b0;
          default:   evt_tgl <= ~evt_tgl;
        endcase
      end
    end
  end

endmodule

// File: rtl/ptp_tt_trig.sv
module ptp_tt_trig
  import ptp_tt_pkg::*;
#(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned NS_W        = 31,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_reg,
  input  logic                  rst_reg_n,
  input  logic                  bus_wr_en,
  input  logic [REG_ADDR_W-1:0] bus_wr_addr,
  input  logic [DATA_W-1:0]     bus_wr_data,
  input  logic [REG_ADDR_W-1:0] bus_rd_addr,
  output logic [DATA_W-1:0]     bus_rd_data,
  output logic                  irq,
  input  logic                  clk_ptp,
  input  logic                  rst_ptp_n,
  input  logic [SEC_W-1:0]      now_sec,
  input  logic [NS_W-1:0]       now_ns,
  output logic                  pps_run
);

  logic             req_tgl;
  logic             req_sync;
  logic             ack_tgl;
  logic             ack_sync;
  logic             evt_tgl;
  logic             evt_sync;
  logic             busy;
  logic             status;
  logic             irq_en;
  logic [SEC_W-1:0] tgt_sec;
  logic [NS_W-1:0]  tgt_ns;
  trig_mode_e       tgt_mode;

  ptp_tt_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk_reg),
    .rst_n    (rst_reg_n),
    .wr_en    (bus_wr_en),
    .wr_addr  (bus_wr_addr),
    .wr_data  (bus_wr_data),
    .rd_addr  (bus_rd_addr),
    .rd_data  (bus_rd_data),
    .ack_sync (ack_sync),
    .evt_sync (evt_sync),
    .req_tgl  (req_tgl),
    .busy     (busy),
    .status   (status),
    .irq_en   (irq_en),
    .tgt_sec  (tgt_sec),
    .tgt_ns   (tgt_ns),
    .tgt_mode (tgt_mode),
    .irq      (irq)
  );

  ptp_tt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_ptp), .rst_n(rst_ptp_n), .d(req_tgl), .q(req_sync)
  );

  ptp_tt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_reg), .rst_n(rst_reg_n), .d(ack_tgl), .q(ack_sync)
  );

  ptp_tt_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk_reg), .rst_n(rst_reg_n), .d(evt_tgl), .q(evt_sync)
  );

  ptp_tt_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
    .clk      (clk_ptp),
    .rst_n    (rst_ptp_n),
    .req_sync (req_sync),
    .src_sec  (tgt_sec),
    .src_ns   (tgt_ns),
    .src_mode (tgt_mode),
    .now_sec  (now_sec),
    .now_ns   (now_ns),
    .ack_tgl  (ack_tgl),
    .evt_tgl  (evt_tgl),
    .pps_run  (pps_run)
  );

endmodule

// File: rtl/ptp_tt_trig_chk.sv
module ptp_tt_trig_chk
  import ptp_tt_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 31,
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk_reg,
  input logic                  rst_reg_n,
  input logic                  clk_ptp,
  input logic                  rst_ptp_n,
  input logic                  bus_wr_en,
  input logic [REG_ADDR_W-1:0] bus_wr_addr,
  input logic [DATA_W-1:0]     bus_wr_data,
  input logic                  busy,
  input logic                  status,
  input logic [SEC_W-1:0]      tgt_sec,
  input logic [NS_W-1:0]       tgt_ns,
  input logic [SEC_W-1:0]      now_sec,
  input logic [NS_W-1:0]       now_ns,
  input logic [SEC_W-1:0]      cap_sec,
  input logic [NS_W-1:0]       cap_ns,
  input trig_mode_e            cap_mode,
  input logic                  armed,
  input logic                  ack_tgl,
  input logic                  evt_tgl,
  input logic                  pps_run
);

  // R2
  busy_rise_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    $rose(busy) |-> $past(bus_wr_en && (bus_wr_addr == A_NS)));

  // R3
  sec_frozen_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    busy |=> $stable(tgt_sec));

  // R3
  ns_frozen_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    busy |=> $stable(tgt_ns));

  // R8
  stat_clear_chk: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    $fell(status) |-> $past(bus_wr_en && (bus_wr_addr == A_STAT) && bus_wr_data[0]));

  // R4
  pps_start_chk: assert property (@(posedge clk_ptp) disable iff (!rst_ptp_n)
    $rose(pps_run) |-> $past(armed && (cap_mode == TRIG_IRQ_START) &&
      ((now_sec > cap_sec) || ((now_sec == cap_sec) && (now_ns >= cap_ns)))));

  // R6
  stop_silent_chk: assert property (@(posedge clk_ptp) disable iff (!rst_ptp_n)
    $fell(pps_run) |-> $stable(evt_tgl));

  // R7
  rearm_chk: assert property (@(posedge clk_ptp) disable iff (!rst_ptp_n)
    $rose(armed) |-> (ack_tgl != $past(ack_tgl)));

  // R7
  disarmed_quiet_chk: assert property (@(posedge clk_ptp) disable iff (!rst_ptp_n)
    (!armed && $stable(ack_tgl)) |=> $stable(evt_tgl));

endmodule

bind ptp_tt_trig ptp_tt_trig_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(DATA_W)) u_chk (
  .clk_reg     (clk_reg),
  .rst_reg_n   (rst_reg_n),
  .clk_ptp     (clk_ptp),
  .rst_ptp_n   (rst_ptp_n),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_addr (bus_wr_addr),
  .bus_wr_data (bus_wr_data),
  .busy        (busy),
  .status      (status),
  .tgt_sec     (tgt_sec),
  .tgt_ns      (tgt_ns),
  .now_sec     (now_sec),
  .now_ns      (now_ns),
  .cap_sec     (u_cmp.cap_sec),
  .cap_ns      (u_cmp.cap_ns),
  .cap_mode    (u_cmp.cap_mode),
  .armed       (u_cmp.armed),
  .ack_tgl     (ack_tgl),
  .evt_tgl     (evt_tgl),
  .pps_run     (pps_run)
);

// File: tb/ptp_tt_trig_bench.sv
`timescale 1ns/1ps
module ptp_tt_trig_bench;

  logic        clk_reg = 1'b0;
  logic        clk_ptp = 1'b0;
  logic        rst_reg_n = 1'b0;
  logic        rst_ptp_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [1:0]  bus_wr_addr = '0;
  logic [31:0] bus_wr_data = '0;
  logic [1:0]  bus_rd_addr = '0;
  logic [31:0] bus_rd_data;
  logic        irq;
  logic [31:0] now_sec = '0;
  logic [30:0] now_ns = '0;
  logic        pps_run;

  always #10 clk_reg = ~clk_reg;
  always #7  clk_ptp = ~clk_ptp;

  ptp_tt_trig u_ptp_tt_trig (
    .clk_reg, .rst_reg_n, .bus_wr_en, .bus_wr_addr, .bus_wr_data,
    .bus_rd_addr, .bus_rd_data, .irq, .clk_ptp, .rst_ptp_n,
    .now_sec, .now_ns, .pps_run
  );

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done  = 1'b0;

  // Time model: linear count, split per rollover style.
  logic [63:0] tot = '0;
  logic [63:0] step = 64'd1;
  logic        bench_dec = 1'b0;
  logic        jump_pend = 1'b0;
  logic [63:0] jump_val = '0;

  // Scoreboard entries: {expected pps level, linear target}.
  logic [64:0] sb[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lin(input logic [31:0] s, input logic [30:0] n, input logic dec);
    if (dec) return 64'(s) * 64'd1_000_000_000 + 64'(n);
    else     return (64'(s) << 31) + 64'(n);
  endfunction

  initial begin
    forever begin
      @(posedge clk_ptp);
      #2;
      if (jump_pend) begin
        tot = jump_val;
        jump_pend = 1'b0;
      end else begin
        tot = tot + step;
      end
      if (bench_dec) begin
        now_sec = 32'(tot / 64'd1_000_000_000);
        now_ns  = 31'(tot % 64'd1_000_000_000);
      end else begin
        now_sec = 32'(tot >> 31);
        now_ns  = tot[30:0];
      end
    end
  end

  // Monitor: pops an expected item on each pps edge.
  initial begin
    logic        prev_pps;
    logic [63:0] prev_tot;
    logic [64:0] item;
    prev_pps = 1'b0;
    prev_tot = '0;
    forever begin
      @(negedge clk_ptp);
      if (pps_run !== prev_pps) begin
        if (sb.size() == 0) begin
          chk("R7 unexpected pps edge", 64'(pps_run), 64'(prev_pps));
        end else begin
          item = sb.pop_front();
          chk("R6 pps level", 64'(pps_run), 64'(item[64]));
          chk("R4 not before target", 64'(prev_tot >= item[63:0]), 64'd1);
          chk("R5 first sample at or past target", 64'(prev_tot < item[63:0] + step), 64'd1);
        end
        prev_pps = pps_run;
      end
      prev_tot = tot;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_reg);
    bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
    @(negedge clk_reg);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd_addr = a;
    #1;
    d = bus_rd_data;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(2'd1, v);
    while (v[31] && cyc < 40) begin
      @(negedge clk_reg);
      cyc++;
      rd(2'd1, v);
    end
  endtask

  task automatic jump(input logic [63:0] v);
    jump_val = v;
    jump_pend = 1'b1;
    @(posedge clk_ptp);
    #3;
  endtask

  task automatic wait_reach(input logic [63:0] t);
    int k = 0;
    while (tot < t + step && k < 100000) begin
      @(negedge clk_ptp);
      k++;
    end
    repeat (12) @(negedge clk_reg);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] t;
    int          cyc;

    repeat (4) @(negedge clk_reg);
    rst_reg_n = 1'b1;
    rst_ptp_n = 1'b1;
    @(negedge clk_reg);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end
    chk("R1 irq reset", 64'(irq), 64'd0);
    chk("R1 pps reset", 64'(pps_run), 64'd0);

    // R11, R2, R3: binary mode, far target, bit 31 write ignored
    wr(2'd2, 32'h0000_0010);
    wr(2'd0, 32'hFFFF_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    chk("R2 busy set after commit", 64'(v[31]), 64'd1);
    wr(2'd0, 32'd99);
    wait_idle(cyc);
    chk("R2 busy clears in bound", 64'(cyc < 20), 64'd1);
    rd(2'd0, v);
    chk("R3 seconds write dropped while busy", 64'(v), 64'hFFFF_0000);
    rd(2'd1, v);
    chk("R11 sub-second field and bit 31", 64'(v), 64'h7FFF_FFFF);

    // R5, R10, R6 mode 2: decimal, coarse step across seconds carry
    wr(2'd2, 32'h0000_0112);
    wr(2'd0, 32'd11);
    step = 64'd7;
    bench_dec = 1'b1;
    jump(64'd10_999_999_000);
    t = lin(32'd11, 31'd3, 1'b1);
    sb.push_back({1'b1, t});
    wr(2'd1, 32'd3);
    repeat (20) @(negedge clk_ptp);
    chk("R4 no event before target", 64'(pps_run), 64'd0);
    wait_reach(t);
    chk("R10 decimal carry fired", 64'(sb.size()), 64'd0);
    rd(2'd3, v);
    chk("R6 mode 2 sets status", 64'(v), 64'd1);
    chk("R8 irq with enable", 64'(irq), 64'd1);
    wr(2'd3, 32'd1);
    rd(2'd3, v);
    chk("R8 write one clears status", 64'(v), 64'd0);
    chk("R8 irq drops with status", 64'(irq), 64'd0);
    repeat (200) @(negedge clk_ptp);
    rd(2'd3, v);
    chk("R7 no second event", 64'(v), 64'd0);
    chk("R7 pps held", 64'(pps_run), 64'd1);

    // R6 mode 3 and R10: binary rollover carry, stop without interrupt
    wr(2'd2, 32'h0000_0013);
    wr(2'd0, 32'd4);
    step = 64'd3;
    bench_dec = 1'b0;
    jump((64'd3 << 31) + 64'h7FFF_FF00);
    t = lin(32'd4, 31'h10, 1'b0);
    sb.push_back({1'b0, t});
    wr(2'd1, 32'h10);
    wait_reach(t);
    chk("R10 binary carry fired", 64'(sb.size()), 64'd0);
    rd(2'd3, v);
    chk("R6 mode 3 no interrupt", 64'(v), 64'd0);

    // R6 mode 1 as interrupt only, R8 masking
    wr(2'd2, 32'h0000_0101);
    wr(2'd0, 32'd30);
    step = 64'd1000;
    bench_dec = 1'b1;
    jump(64'd30_000_000_000);
    t = lin(32'd30, 31'd50_000, 1'b1);
    wr(2'd1, 32'd50_000);
    wait_reach(t);
    rd(2'd3, v);
    chk("R6 mode 1 sets status", 64'(v), 64'd1);
    chk("R6 mode 1 leaves pps", 64'(pps_run), 64'd0);
    chk("R8 irq masked", 64'(irq), 64'd0);
    wr(2'd2, 32'h0000_0111);
    chk("R8 irq unmasked", 64'(irq), 64'd1);
    wr(2'd3, 32'd1);

    // R9: decimal range limit, binary accepts
    wr(2'd1, 32'd1_000_000_000);
    rd(2'd1, v);
    chk("R9 out-of-range dropped no busy", 64'(v), 64'd50_000);
    jump(64'd0);
    wr(2'd2, 32'h0000_0010);
    bench_dec = 1'b0;
    wr(2'd1, 32'd1_000_000_000);
    wait_idle(cyc);
    rd(2'd1, v);
    chk("R9 binary accepts large value", 64'(v), 64'd1_000_000_000);
    wr(2'd2, 32'h0000_0110);
    wr(2'd1, 32'd999_999_999);
    wait_idle(cyc);
    rd(2'd1, v);
    chk("R9 decimal limit accepted", 64'(v), 64'd999_999_999);

    repeat (20) @(negedge clk_reg);
    chk("R7 scoreboard drained", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule